// File: doc/BRIEF.md
# Masked Bit-Set Port Register

This block is a four-bit general-purpose port. Software can set or clear any subset of the port bits with a single byte write, and needs no read-modify-write sequence. The upper nibble of each written byte is a per-bit protect mask for the lower nibble. A protected bit keeps its value. An unprotected bit takes the new data. Two unrelated agents can therefore change different bits of the same port without racing each other.

Each bit has a polarity control that inverts its data path in both directions. Each bit also has an open-drain control that turns its output into a pull-down-only driver. A read of the data location returns the state of the pins after a synchronizer, not the contents of the output register. A host on a simple register bus uses the block, and the block drives the pad-side signals pin out and output enable.

Top module: `maskset_port`

## Requirements
- R1: Synchronous reset (active high) clears the output level register, the polarity bits and the open-drain bits. After reset, `pin_out` is 0, `pin_oe` is 4'hF, and reads of locations 1 and 2 return 8'h00.
- R2: A write to location 0 updates bit i (i = 0..3) of the output level register to `bus_wdata[i]` when `bus_wdata[i+4]` is 0. When `bus_wdata[i+4]` is 1, the bit keeps its previous value.
- R3: A read of location 0 returns the pins after a two-flop synchronizer, XORed with the polarity bits, in bits 3:0, with bits 7:4 equal to 0. The output level register is not returned.
- R4: Location 1 holds the polarity bits in bits 3:0. Written bits 7:4 are discarded, and a read returns the stored nibble with bits 7:4 equal to 0.
- R5: Location 2 holds the open-drain bits in bits 3:0. It is written and read the same way as location 1.
- R6: A bit whose open-drain bit is 0 has `pin_oe` = 1 and `pin_out` equal to its level bit XOR its polarity bit.
- R7: A bit whose open-drain bit is 1 has `pin_out` = 0 and `pin_oe` equal to the inverse of (level XOR polarity). Such a bit never drives high.
- R8: `bus_rdata` is registered. It presents the addressed value on the clock edge that samples `bus_rd` and holds it until the next read.
- R9: Location 3 is unused. Writes to it change no state and no pin, and reads of it return 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 2 | Location: 0 data, 1 polarity, 2 open-drain, 3 unused |
| bus_wdata | input | 8 | Write byte: protect mask in 7:4, data in 3:0 |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 4 | Pad input levels |
| pin_out | output | 4 | Pad output levels |
| pin_oe | output | 4 | Pad output enables, 1 drives |

## Verification
A corrupted level bit appears at `pin_out` or `pin_oe` in the cycle right after the write that caused it. The checks therefore sample the pad side directly after each masked write, and use masks that protect alternating bits, all bits and no bits. A wrong polarity or open-drain bit is visible both at the pads and on a readback one cycle after the read strobe. Pin reads are checked only after the two synchronizer stages have settled. This separates a bad inversion on the read path from plain latency.

// File: rtl/maskset_pkg.sv
package maskset_pkg;

    localparam int PORT_W = 4;
    localparam int BUS_W  = 2 * PORT_W;

    typedef enum logic [1:0] {
        SEL_LEVEL  = 2'd0,
        SEL_POL    = 2'd1,
        SEL_ODRAIN = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    typedef logic [PORT_W-1:0] nib_t;

    typedef struct packed {
        nib_t level;
        nib_t pol;
        nib_t odrain;
    } port_cfg_t;

    typedef struct packed {
        nib_t prot;
        nib_t data;
    } wr_byte_t;

    // Protected bits keep old, open bits take data.
    function automatic nib_t merge_masked(nib_t old_v, nib_t data_v, nib_t prot_v);
        return (old_v & prot_v) | (data_v & ~prot_v);
    endfunction

    function automatic nib_t apply_pol(nib_t v, nib_t pol);
        return v ^ pol;
    endfunction

    function automatic logic [BUS_W-1:0] widen(nib_t v);
        return {{(BUS_W-PORT_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/maskset_sync.sv
module maskset_sync
    import maskset_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  nib_t async_in,
    output nib_t sync_out
);
    localparam int LAST = STAGES - 1;

    nib_t chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[LAST];

endmodule

// File: rtl/maskset_regs.sv
module maskset_regs
    import maskset_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [BUS_W-1:0] wdata,
    output port_cfg_t        cfg
);
    wr_byte_t  wb;
    port_cfg_t cfg_q, cfg_d;

    assign wb = wr_byte_t'(wdata);

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (sel)
                SEL_LEVEL:  cfg_d.level  = merge_masked(cfg_q.level, wb.data, wb.prot);
                SEL_POL:    cfg_d.pol    = wb.data;
                SEL_ODRAIN: cfg_d.odrain = wb.data;
                SEL_SPARE:  cfg_d        = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (cfg_q == '0)); // R1

    AST_PROTECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_LEVEL) |=>
            (((cfg_q.level ^ $past(cfg_q.level)) & $past(wb.prot)) == '0)); // R2

    AST_OPEN_BITS_TAKE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_LEVEL) |=>
            (((cfg_q.level ^ $past(wb.data)) & ~$past(wb.prot)) == '0)); // R2

    AST_SPARE_INERT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_SPARE) |=> $stable(cfg_q)); // R9

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_q)); // R4

endmodule

// File: rtl/maskset_drive.sv
module maskset_drive
    import maskset_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  port_cfg_t cfg,
    output nib_t      pin_out,
    output nib_t      pin_oe
);
    nib_t phys;

    assign phys = apply_pol(cfg.level, cfg.pol);

    genvar b;
    generate
        for (b = 0; b < PORT_W; b++) begin : g_bit
            always_comb begin
                if (cfg.odrain[b]) begin
                    pin_out[b] = 1'b0;
                    pin_oe[b]  = ~phys[b];
                end else begin
                    pin_out[b] = phys[b];
                    pin_oe[b]  = 1'b1;
                end
            end
        end
    endgenerate

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe & pin_out & cfg.odrain) == '0)); // R7

    AST_PP_ALWAYS_DRIVES: assert property (@(posedge clk) disable iff (rst)
        ((~pin_oe & ~cfg.odrain) == '0)); // R6

endmodule

// File: rtl/maskset_port.sv
module maskset_port
    import maskset_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    reg_sel_e   sel;
    port_cfg_t  cfg;
    nib_t       pins_sync;
    logic [BUS_W-1:0] rd_mux, rdata_q;

    assign sel = reg_sel_e'(bus_addr);

    maskset_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    maskset_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .cfg   (cfg)
    );

    maskset_drive u_drive (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    always_comb begin
        unique case (sel)
            SEL_LEVEL:  rd_mux = widen(apply_pol(pins_sync, cfg.pol));
            SEL_POL:    rd_mux = widen(cfg.pol);
            SEL_ODRAIN: rd_mux = widen(cfg.odrain);
            SEL_SPARE:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[BUS_W-1:PORT_W] == '0)); // R3

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata)); // R8

    AST_SPARE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == SEL_SPARE) |=> (bus_rdata == '0)); // R9

endmodule

// File: tb/maskset_port_tb_top.sv
module maskset_port_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] pin_in = '0;
    logic [3:0] pin_out, pin_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    maskset_port dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // scoreboard queues
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       issued = 1'b0;

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) issued <= bus_rd && !rst;

    always @(negedge clk) begin
        if (issued) begin
            if (exp_q.size() == 0) check("R8 unexpected read", bus_rdata, 8'hxx);
            else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pads(logic [3:0] eo, logic [3:0] ee, string tag);
        check(tag, {4'h0, pin_out}, {4'h0, eo});
        check(tag, {4'h0, pin_oe},  {4'h0, ee});
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        pads(4'h0, 4'hF, "R1 reset pads");
        rd(2'd1, 8'h00, "R1 reset polarity");
        rd(2'd2, 8'h00, "R1 reset open-drain");

        wr(2'd0, 8'h0F); pads(4'hF, 4'hF, "R2 R6 open mask sets all");
        wr(2'd0, 8'hA0); pads(4'hA, 4'hF, "R2 protect bits 1,3");
        wr(2'd0, 8'h55); pads(4'h0, 4'hF, "R2 protect bits 0,2");
        wr(2'd0, 8'h0B); pads(4'hB, 4'hF, "R2 pattern B");
        wr(2'd0, 8'hF0); pads(4'hB, 4'hF, "R2 full protect holds");

        wr(2'd1, 8'h06); pads(4'hD, 4'hF, "R6 polarity inverts drive");
        rd(2'd1, 8'h06, "R4 polarity readback");
        wr(2'd1, 8'hF6); rd(2'd1, 8'h06, "R4 upper nibble discarded");

        pin_in = 4'h3; repeat (3) @(negedge clk);
        rd(2'd0, 8'h05, "R3 pins through polarity");
        pin_in = 4'hC; repeat (3) @(negedge clk);
        rd(2'd0, 8'h0A, "R3 pins not level register");

        wr(2'd2, 8'h09); pads(4'h4, 4'h6, "R7 open-drain released high");
        rd(2'd2, 8'h09, "R5 open-drain readback");
        wr(2'd0, 8'h00); pads(4'h6, 4'hF, "R7 open-drain pulls low");

        wr(2'd3, 8'hFF);
        pads(4'h6, 4'hF, "R9 spare write no pin effect");
        rd(2'd3, 8'h00, "R9 spare read zero");
        rd(2'd1, 8'h06, "R9 polarity untouched");
        rd(2'd2, 8'h09, "R9 open-drain untouched");
        @(negedge clk);
        check("R8 rdata held", bus_rdata, 8'h09);

        do_reset();
        pads(4'h0, 4'hF, "R1 second reset pads");
        rd(2'd1, 8'h00, "R1 second reset polarity");
        rd(2'd2, 8'h00, "R1 second reset open-drain");
        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) check("R8 missing read", 8'h00, 8'h01);
        done = 1;
    end

    initial begin : watchdog
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule